// File: doc/BRIEF.md
# Fiber Link Supervisor with Parallel-Detect Fallback

This block sits beside a hardware auto-negotiation engine on a 1000 Mb/s fiber link and decides, once per polling strobe, what that engine should be doing and whether the link may be declared usable. It takes the receive-side line conditions (PCS synchronisation, signal detect, config words being received) and the engine's completion flag and partner pause bits. It also takes the local wishes: whether auto-negotiation is wanted, and whether transmit and/or receive flow control is desired. From these it drives the engine control word (enable, two pause advertisement bits) plus a soft-reset pulse.

When negotiation does not complete within a timeout, the block switches the engine off and waits a settle interval. If the PCS is then synchronised and no config words are arriving, the partner is taken to be a fixed-speed device. The link is declared up in parallel-detect mode, and that mode is kept for a separate countdown before negotiation is tried again. Link-up always means 1000 Mb/s full duplex.

Top module: `fiber_link_sup`

## Requirements
- R1: On a poll with the negotiation request low, the engine word becomes all zero (no enable, no pause bits), partner pause outputs read 0, and `link_up` follows `pcs_sync` as sampled at that poll.
- R2: With negotiation requested, the advertised pause bits (`eng_pause`, `eng_asym`) encode flow control as follows: transmit and receive gives 1,0; transmit only gives 0,1; receive only gives 1,1; neither gives 0,0.
- R3: On a poll where the requested word (enable=1 plus the R2 bits) differs from the applied word, the new word is applied and `eng_srst` is high for exactly SRST_CYCLES clock cycles starting the cycle after the poll. The countdown reloads with AN_TIMEOUT and parallel-detect mode clears.
- R4: In parallel-detect mode, with the countdown non-zero, PCS synced and no config words, a word mismatch does not restart: the countdown decrements and the link stays up. Once the countdown is zero, or config words appear, the R3 restart happens.
- R5: With the word applied and sync or signal detect present, a poll with `an_done` and `pcs_sync` high reports link up and copies the partner pause bits to `lp_pause`/`lp_asym`, clears the countdown and leaves parallel-detect mode. On every other poll the partner outputs read 0.
- R6: With the word applied, sync or signal detect present and `an_done` low, each poll decrements a non-zero countdown with the link down. A poll finding it zero turns the engine enable off and starts a settle interval.
- R7: After the settle poll, SETTLE_POLLS further polls pass with the link down. The next poll declares link up in parallel-detect mode with the countdown loaded to PD_TIMEOUT if `pcs_sync` is high and `cfg_rx` low; otherwise it performs the R3 restart.
- R8: With the word applied and neither sync nor signal detect present, a poll reports link down, reloads the countdown with AN_TIMEOUT and clears parallel-detect mode.
- R9: `speed_code` is 2'b10 (1000 Mb/s) and `duplex_code` is 2'b01 (full) while `link_up` is high; both are 2'b11 (unknown) otherwise.
- R10: Any poll on which `link_up` falls clears `pdet_mode`. Parallel-detect mode is never set while the link is down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| poll_stb | input | 1 | One-cycle strobe: evaluate the link once |
| pcs_sync | input | 1 | PCS has code-group synchronisation |
| sig_det | input | 1 | Optical signal detected |
| cfg_rx | input | 1 | Config code words are being received |
| an_done | input | 1 | Engine reports negotiation complete |
| lp_pause_in | input | 1 | Partner advertised symmetric pause |
| lp_asym_in | input | 1 | Partner advertised asymmetric pause |
| an_want | input | 1 | Auto-negotiation requested |
| fc_tx | input | 1 | Transmit flow control desired |
| fc_rx | input | 1 | Receive flow control desired |
| eng_en | output | 1 | Engine enable (applied word) |
| eng_pause | output | 1 | Engine symmetric-pause advertisement |
| eng_asym | output | 1 | Engine asymmetric-pause advertisement |
| eng_srst | output | 1 | Engine soft-reset pulse |
| link_up | output | 1 | Link declared usable |
| pdet_mode | output | 1 | Link is up through parallel detection |
| lp_pause | output | 1 | Captured partner symmetric pause |
| lp_asym | output | 1 | Captured partner asymmetric pause |
| speed_code | output | 2 | 2'b10 = 1000 Mb/s, 2'b11 = unknown |
| duplex_code | output | 2 | 2'b01 = full, 2'b11 = unknown |

## Verification
The bench walks the supervisor through the forced-off case, with sync both present and absent, and all four flow-control combinations. Each combination must give a distinct restart word. It separates a partner that negotiates from one that stays silent after the timeout, and a silent partner that sends no config words (parallel detect) from one that still does (a second restart). Parallel-detect hold is run to the end of its countdown and also broken early by config words. A link drop while negotiation is off shows that parallel-detect mode clears with the link and not only on restart.

// File: rtl/fls_pkg.sv
// Package: shared types for the fiber link supervisor.
// Assumes nothing beyond IEEE 1800-2017.
package fls_pkg;

    // Engine control word: bit 2 enable, bit 1 symmetric pause, bit 0 asymmetric pause.
    typedef struct packed {
        logic en;
        logic pause;
        logic asym;
    } fls_word_t;

    localparam logic [1:0] SPD_1000  = 2'b10;
    localparam logic [1:0] DUP_FULL  = 2'b01;
    localparam logic [1:0] CODE_UNKN = 2'b11;

endpackage

// File: rtl/fls_adv_enc.sv
// Module: fls_adv_enc
// Builds the requested engine word from the negotiation request and the
// desired flow-control directions. Purely combinational.
// Assumes: the word is all zero when negotiation is not requested.
module fls_adv_enc
    import fls_pkg::*;
(
    input  logic      an_want,
    input  logic      fc_tx,
    input  logic      fc_rx,
    output fls_word_t req
);

    // Map the flow-control wishes onto the two advertisement bits.
    always_comb begin
        req = '0;
        if (an_want) begin
            req.en = 1'b1;
            unique case ({fc_tx, fc_rx})
                2'b11:   begin req.pause = 1'b1; req.asym = 1'b0; end
                2'b10:   begin req.pause = 1'b0; req.asym = 1'b1; end
                2'b01:   begin req.pause = 1'b1; req.asym = 1'b1; end
                default: begin req.pause = 1'b0; req.asym = 1'b0; end
            endcase
        end
    end

endmodule

// File: rtl/fls_srst_pulse.sv
// Module: fls_srst_pulse
// Stretches a one-cycle start request into a soft-reset pulse of CYCLES
// clock cycles, beginning the cycle after the request.
// Assumes: CYCLES >= 1; a new request restarts the pulse.
module fls_srst_pulse #(
    parameter int CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic pulse
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    // Load on request, count down to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (start)      cnt_q <= CW'(CYCLES);
        else if (cnt_q != 0) cnt_q <= cnt_q - CW'(1);
    end

    assign pulse = (cnt_q != '0);

endmodule

// File: rtl/fls_ctrl.sv
// Module: fls_ctrl
// Poll-driven supervisor core: holds the applied engine word, the shared
// negotiation / parallel-detect countdown, the settle counter and the
// registered link results. All state moves only on a poll strobe.
// Assumes: poll is a single-cycle strobe; timeouts are counted in polls.
module fls_ctrl
    import fls_pkg::*;
#(
    parameter int AN_TIMEOUT   = 200,
    parameter int PD_TIMEOUT   = 100,
    parameter int SETTLE_POLLS = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      poll,
    input  logic      pcs_sync,
    input  logic      sig_det,
    input  logic      cfg_rx,
    input  logic      an_done,
    input  logic      lp_pause_in,
    input  logic      lp_asym_in,
    input  logic      an_want,
    input  fls_word_t req,
    output fls_word_t applied,
    output logic      restart,
    output logic      link_q,
    output logic      pdet_q,
    output logic      lpp_q,
    output logic      lpa_q
);

    localparam int TMAX = (AN_TIMEOUT > PD_TIMEOUT) ? AN_TIMEOUT : PD_TIMEOUT;
    localparam int CW   = $clog2(TMAX + 1);
    localparam int SW   = $clog2(SETTLE_POLLS + 1);

    fls_word_t     app_q, app_n;
    logic [CW-1:0] cnt_q, cnt_n;
    logic [SW-1:0] scnt_q, scnt_n;
    logic          set_q, set_n;
    logic          link_n, pdet_n, lpp_n, lpa_n;
    logic          do_rst;
    logic          quiet_sync;

    assign quiet_sync = pcs_sync && !cfg_rx;

    // Next-state decision for one poll.
    always_comb begin
        app_n  = app_q;
        cnt_n  = cnt_q;
        scnt_n = scnt_q;
        set_n  = set_q;
        link_n = link_q;
        pdet_n = pdet_q;
        lpp_n  = lpp_q;
        lpa_n  = lpa_q;
        do_rst = 1'b0;
        if (poll) begin
            link_n = 1'b0;
            lpp_n  = 1'b0;
            lpa_n  = 1'b0;
            if (!an_want) begin
                app_n  = '0;
                set_n  = 1'b0;
                link_n = pcs_sync;
            end else if (set_q) begin
                if (scnt_q != '0) begin
                    scnt_n = scnt_q - SW'(1);
                end else begin
                    set_n = 1'b0;
                    if (quiet_sync) begin
                        link_n = 1'b1;
                        pdet_n = 1'b1;
                        cnt_n  = CW'(PD_TIMEOUT);
                    end else begin
                        do_rst = 1'b1;
                    end
                end
            end else if (app_q != req) begin
                if (pdet_q && (cnt_q != '0) && quiet_sync) begin
                    cnt_n  = cnt_q - CW'(1);
                    link_n = 1'b1;
                end else begin
                    do_rst = 1'b1;
                end
            end else if (pcs_sync || sig_det) begin
                if (an_done && pcs_sync) begin
                    link_n = 1'b1;
                    lpp_n  = lp_pause_in;
                    lpa_n  = lp_asym_in;
                    cnt_n  = '0;
                    pdet_n = 1'b0;
                end else if (!an_done) begin
                    if (cnt_q != '0) begin
                        cnt_n = cnt_q - CW'(1);
                    end else begin
                        app_n  = '0;
                        set_n  = 1'b1;
                        scnt_n = SW'(SETTLE_POLLS);
                    end
                end
            end else begin
                cnt_n  = CW'(AN_TIMEOUT);
                pdet_n = 1'b0;
            end
            if (do_rst) begin
                app_n  = req;
                cnt_n  = CW'(AN_TIMEOUT);
                pdet_n = 1'b0;
            end
            if (link_q && !link_n) pdet_n = 1'b0;
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            app_q  <= '0;
            cnt_q  <= CW'(AN_TIMEOUT);
            scnt_q <= '0;
            set_q  <= 1'b0;
            link_q <= 1'b0;
            pdet_q <= 1'b0;
            lpp_q  <= 1'b0;
            lpa_q  <= 1'b0;
        end else begin
            app_q  <= app_n;
            cnt_q  <= cnt_n;
            scnt_q <= scnt_n;
            set_q  <= set_n;
            link_q <= link_n;
            pdet_q <= pdet_n;
            lpp_q  <= lpp_n;
            lpa_q  <= lpa_n;
        end
    end

    assign applied = app_q;
    assign restart = do_rst;

endmodule

// File: rtl/fiber_link_sup.sv
// Module: fiber_link_sup (top)
// Supervises a fiber auto-negotiation engine with a parallel-detect fallback.
// Assumes: poll_stb pulses for one clock per evaluation; reset is
// synchronous and active low; the engine samples its word continuously.
module fiber_link_sup
    import fls_pkg::*;
#(
    parameter int AN_TIMEOUT   = 200,
    parameter int PD_TIMEOUT   = 100,
    parameter int SETTLE_POLLS = 4,
    parameter int SRST_CYCLES  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       poll_stb,
    input  logic       pcs_sync,
    input  logic       sig_det,
    input  logic       cfg_rx,
    input  logic       an_done,
    input  logic       lp_pause_in,
    input  logic       lp_asym_in,
    input  logic       an_want,
    input  logic       fc_tx,
    input  logic       fc_rx,
    output logic       eng_en,
    output logic       eng_pause,
    output logic       eng_asym,
    output logic       eng_srst,
    output logic       link_up,
    output logic       pdet_mode,
    output logic       lp_pause,
    output logic       lp_asym,
    output logic [1:0] speed_code,
    output logic [1:0] duplex_code
);

    fls_word_t req_w;
    fls_word_t app_w;
    logic      rst_req;

    fls_adv_enc u_enc (
        .an_want (an_want),
        .fc_tx   (fc_tx),
        .fc_rx   (fc_rx),
        .req     (req_w)
    );

    fls_ctrl #(
        .AN_TIMEOUT   (AN_TIMEOUT),
        .PD_TIMEOUT   (PD_TIMEOUT),
        .SETTLE_POLLS (SETTLE_POLLS)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .poll        (poll_stb),
        .pcs_sync    (pcs_sync),
        .sig_det     (sig_det),
        .cfg_rx      (cfg_rx),
        .an_done     (an_done),
        .lp_pause_in (lp_pause_in),
        .lp_asym_in  (lp_asym_in),
        .an_want     (an_want),
        .req         (req_w),
        .applied     (app_w),
        .restart     (rst_req),
        .link_q      (link_up),
        .pdet_q      (pdet_mode),
        .lpp_q       (lp_pause),
        .lpa_q       (lp_asym)
    );

    fls_srst_pulse #(
        .CYCLES (SRST_CYCLES)
    ) u_srst (
        .clk   (clk),
        .rst_n (rst_n),
        .start (rst_req),
        .pulse (eng_srst)
    );

    assign eng_en      = app_w.en;
    assign eng_pause   = app_w.pause;
    assign eng_asym    = app_w.asym;
    assign speed_code  = link_up ? SPD_1000 : CODE_UNKN;
    assign duplex_code = link_up ? DUP_FULL : CODE_UNKN;

endmodule

// File: rtl/fls_chk.sv
// Module: fls_chk
// Protocol checker for fiber_link_sup, attached by bind below.
// Assumes: same clock and synchronous active-low reset as the design.
module fls_chk (
    input logic clk,
    input logic rst_n,
    input logic poll_stb,
    input logic pcs_sync,
    input logic an_want,
    input logic eng_en,
    input logic eng_pause,
    input logic eng_asym,
    input logic eng_srst,
    input logic link_up,
    input logic pdet_mode,
    input logic lp_pause,
    input logic lp_asym
);

    AST_FORCED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_stb && !an_want) |=> (link_up == $past(pcs_sync)) && !eng_en
                                   && !eng_pause && !eng_asym && !lp_pause && !lp_asym); // R1

    AST_SRST_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_srst) |-> eng_en); // R3

    AST_SRST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_srst && $past(eng_srst)) |-> $stable({eng_en, eng_pause, eng_asym})); // R3

    AST_PARTNER_NEEDS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_pause || lp_asym) |-> link_up); // R5

    AST_NO_SYNC_NO_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_stb && !pcs_sync) |=> !link_up && !pdet_mode); // R8

    AST_PDET_NEEDS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        pdet_mode |-> link_up); // R10

endmodule

bind fiber_link_sup fls_chk u_fls_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .poll_stb  (poll_stb),
    .pcs_sync  (pcs_sync),
    .an_want   (an_want),
    .eng_en    (eng_en),
    .eng_pause (eng_pause),
    .eng_asym  (eng_asym),
    .eng_srst  (eng_srst),
    .link_up   (link_up),
    .pdet_mode (pdet_mode),
    .lp_pause  (lp_pause),
    .lp_asym   (lp_asym)
);

// File: tb/fiber_link_sup_tb_top.sv
// Scoreboard bench: the driver issues polls, predicts the outcome from the
// requirements and queues it; the monitor pops and compares after each poll.
module fiber_link_sup_tb_top;

    localparam int AN_T = 6;
    localparam int PD_T = 4;
    localparam int ST_P = 2;
    localparam int SR_C = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic poll_stb = 1'b0;
    logic pcs_sync = 1'b0, sig_det = 1'b0, cfg_rx = 1'b0, an_done = 1'b0;
    logic lp_pause_in = 1'b0, lp_asym_in = 1'b0;
    logic an_want = 1'b0, fc_tx = 1'b0, fc_rx = 1'b0;
    logic eng_en, eng_pause, eng_asym, eng_srst, link_up, pdet_mode, lp_pause, lp_asym;
    logic [1:0] speed_code, duplex_code;

    always #2.5 clk = ~clk;

    fiber_link_sup #(
        .AN_TIMEOUT (AN_T), .PD_TIMEOUT (PD_T),
        .SETTLE_POLLS (ST_P), .SRST_CYCLES (SR_C)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .poll_stb (poll_stb),
        .pcs_sync (pcs_sync), .sig_det (sig_det), .cfg_rx (cfg_rx), .an_done (an_done),
        .lp_pause_in (lp_pause_in), .lp_asym_in (lp_asym_in),
        .an_want (an_want), .fc_tx (fc_tx), .fc_rx (fc_rx),
        .eng_en (eng_en), .eng_pause (eng_pause), .eng_asym (eng_asym), .eng_srst (eng_srst),
        .link_up (link_up), .pdet_mode (pdet_mode), .lp_pause (lp_pause), .lp_asym (lp_asym),
        .speed_code (speed_code), .duplex_code (duplex_code)
    );

    typedef struct {
        string    tag;
        logic [2:0] word;
        logic     link;
        logic     pd;
        logic     lpp;
        logic     lpa;
        logic     srst;
    } exp_t;

    exp_t exp_q[$];
    event smp_ev;
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    // reference state, built from the requirement text
    logic [2:0] m_app = 3'b000;
    int   m_cnt = AN_T;
    int   m_scnt = 0;
    logic m_set = 1'b0, m_pd = 1'b0, m_link = 1'b0;

    task automatic chk(input string tag, input string what, input int act, input int expv);
        n_run++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    function automatic logic [2:0] req_word();
        if (!an_want) return 3'b000;
        case ({fc_tx, fc_rx})
            2'b11:   return 3'b110;
            2'b10:   return 3'b101;
            2'b01:   return 3'b111;
            default: return 3'b100;
        endcase
    endfunction

    task automatic do_poll(input string tag);
        exp_t e;
        logic nl, np, rs, lpp_e, lpa_e;
        logic [2:0] rq;
        int hi;
        rq = req_word();
        nl = 1'b0; np = m_pd; rs = 1'b0; lpp_e = 1'b0; lpa_e = 1'b0;
        if (!an_want) begin
            m_app = 3'b000; m_set = 1'b0; nl = pcs_sync;
        end else if (m_set) begin
            if (m_scnt != 0) m_scnt--;
            else begin
                m_set = 1'b0;
                if (pcs_sync && !cfg_rx) begin nl = 1'b1; np = 1'b1; m_cnt = PD_T; end
                else rs = 1'b1;
            end
        end else if (m_app != rq) begin
            if (m_pd && m_cnt != 0 && pcs_sync && !cfg_rx) begin m_cnt--; nl = 1'b1; end
            else rs = 1'b1;
        end else if (pcs_sync || sig_det) begin
            if (an_done && pcs_sync) begin
                nl = 1'b1; lpp_e = lp_pause_in; lpa_e = lp_asym_in; m_cnt = 0; np = 1'b0;
            end else if (!an_done) begin
                if (m_cnt != 0) m_cnt--;
                else begin m_app = 3'b000; m_set = 1'b1; m_scnt = ST_P; end
            end
        end else begin
            m_cnt = AN_T; np = 1'b0;
        end
        if (rs) begin m_app = rq; m_cnt = AN_T; np = 1'b0; end
        if (m_link && !nl) np = 1'b0;
        m_link = nl; m_pd = np;
        e.tag = tag; e.word = m_app; e.link = nl; e.pd = np;
        e.lpp = lpp_e; e.lpa = lpa_e; e.srst = rs;
        poll_stb = 1'b1;
        @(negedge clk);
        poll_stb = 1'b0;
        exp_q.push_back(e);
        -> smp_ev;
        // soft-reset pulse width, counted from this sample
        hi = 0;
        for (int i = 0; i < SR_C + 3; i++) begin
            if (eng_srst) hi++;
            @(negedge clk);
        end
        chk("R3", "srst width", hi, rs ? SR_C : 0);
    endtask

    task automatic set_line(input logic s, input logic sd, input logic c, input logic d);
        pcs_sync = s; sig_det = sd; cfg_rx = c; an_done = d;
    endtask

    // monitor: pop one expectation per poll and compare at the ports
    initial begin
        exp_t e;
        forever begin
            @(smp_ev);
            e = exp_q.pop_front();
            chk(e.tag, "word", {eng_en, eng_pause, eng_asym}, e.word);
            chk(e.tag, "link", link_up, e.link);
            chk(e.tag, "pdet", pdet_mode, e.pd);
            chk(e.tag, "lp_pause", lp_pause, e.lpp);
            chk(e.tag, "lp_asym", lp_asym, e.lpa);
            chk("R9", "speed", speed_code, e.link ? 2 : 3);
            chk("R9", "duplex", duplex_code, e.link ? 1 : 3);
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic reach_pdet();
        set_line(1, 1, 1, 0);
        for (int i = 0; i < AN_T; i++) do_poll("R6");
        do_poll("R6");
        for (int i = 0; i < ST_P; i++) do_poll("R7");
        set_line(1, 1, 0, 0);
        do_poll("R7");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", "reset link", link_up, 0);
        chk("R9", "reset speed", speed_code, 3);
        chk("R1", "reset word", {eng_en, eng_pause, eng_asym}, 0);
        chk("R3", "reset srst", eng_srst, 0);

        // R1 forced-off
        set_line(1, 1, 0, 0); do_poll("R1");
        set_line(0, 0, 0, 0); do_poll("R1");

        // R3/R2 restart and completion
        an_want = 1'b1; fc_tx = 1'b1; fc_rx = 1'b1;
        set_line(1, 1, 1, 0); do_poll("R3");
        set_line(1, 1, 0, 1); lp_pause_in = 1'b1; lp_asym_in = 1'b0; do_poll("R5");
        lp_pause_in = 1'b0; lp_asym_in = 1'b1; do_poll("R5");
        lp_asym_in = 1'b0;
        fc_rx = 1'b0; do_poll("R2");
        fc_tx = 1'b0; fc_rx = 1'b1; do_poll("R2");
        fc_rx = 1'b0; do_poll("R2");
        fc_tx = 1'b1; fc_rx = 1'b1; do_poll("R2");

        // R8 loss of everything
        set_line(0, 0, 0, 0); do_poll("R8");

        // R6/R7 timeout into parallel detect, R4 hold to expiry
        reach_pdet();
        set_line(1, 1, 0, 0);
        for (int i = 0; i < PD_T; i++) do_poll("R4");
        do_poll("R4");

        // R7 settle ends with config words present: restart
        set_line(1, 1, 1, 0);
        for (int i = 0; i < AN_T + 1 + ST_P; i++) do_poll("R6");
        do_poll("R7");

        // R4 hold broken early by config words
        reach_pdet();
        set_line(1, 1, 1, 0); do_poll("R4");

        // R10 link drop clears parallel-detect mode
        reach_pdet();
        an_want = 1'b0; set_line(1, 1, 0, 0); do_poll("R10");
        set_line(0, 0, 0, 0); do_poll("R10");
        set_line(1, 1, 0, 0); do_poll("R10");

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule